// File: doc/BRIEF.md
# User-Level Timer Access Trap Decoder

This block decides, within a single combinational path, whether an attempt by user-level software to touch a counter or timer register must be diverted to a more privileged handler. It also supplies the exception class code that the handler will see. The decision depends on four user-access enable bits held in a kernel-owned control word, on a host-mode override, on which counter or timer register is targeted, and on how the access is encoded (64-bit system instruction, 32-bit single-register transfer, or 32-bit double-register transfer).

The instruction decoder places the access description on the inputs. In the same cycle it reads back a trap flag and a 6-bit class code. Choosing the privilege level that receives the trap and actually raising the exception are done elsewhere. There is no storage inside, and nothing flows through it as a stream, so all pins are plain control signals with no handshake.

Top module: `timer_trap_decoder`

## Requirements
- R1: With target code 3 (physical timer group), a user access traps exactly when control bit 9 is 0.
- R2: With target code 4 (virtual timer group), a user access traps exactly when control bit 8 is 0.
- R3: With target code 1 (virtual counter), a user access traps exactly when control bit 1 is 0.
- R4: With target code 0 (physical counter), a user access traps exactly when control bit 0 is 0.
- R5: With target code 2 (frequency register), a user access traps only when control bits 0 and 1 are both 0.
- R6: A trapped access with style code 0 (64-bit system instruction) reports class 0x18.
- R7: A trapped access with style code 1 (32-bit single transfer) reports class 0x03. With style code 2 (32-bit double transfer) it reports class 0x04. Style code 3 never traps.
- R8: While host_override is 1, no access traps.
- R9: While user_level is 0 (the access comes from a privileged level), no access traps.
- R10: Whenever trap is 0, syndrome is 0x00.
- R11: Target codes 5, 6 and 7 name no covered register and never trap.
- R12: Control bits other than 0, 1, 8 and 9 have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| kctl | input | KCTL_W (32) | Kernel control word; bit 0 physical counter enable, bit 1 virtual counter enable, bit 8 virtual timer enable, bit 9 physical timer enable |
| host_override | input | 1 | Host-mode override; when 1, no control here traps |
| user_level | input | 1 | 1 when the access is made at user level |
| target | input | 3 | Register addressed: 0 phys counter, 1 virt counter, 2 frequency, 3 phys timer group, 4 virt timer group, 5..7 uncovered |
| style | input | 2 | Access encoding: 0 64-bit system, 1 32-bit single, 2 32-bit double, 3 reserved |
| trap | output | 1 | Access must trap |
| syndrome | output | 6 | Exception class code, zero when trap is 0 |

## Verification
Directed patterns sweep each enable bit on its own against every target. This separates a decoder that reads the wrong bit position from one that reads the right one. For the frequency register, all four combinations of the two counter enables are applied, which tells a joint AND guard apart from an OR guard or a single-bit guard. Each style code is paired with a trapping access, so a swapped class code shows up. Random words with the four enable bits held fixed and the other bits scrambled expose any leak from unrelated bits, and random override and privilege values show whether the gating dominates every other input.

// File: rtl/timer_trap_pkg.sv
package timer_trap_pkg;
  localparam int EC_W = 6;

  // Positions of the enable bits in the kernel control word
  localparam int PCNT_EN_BIT = 0;
  localparam int VCNT_EN_BIT = 1;
  localparam int VTMR_EN_BIT = 8;
  localparam int PTMR_EN_BIT = 9;
  localparam int MIN_KCTL_W  = PTMR_EN_BIT + 1;

  localparam logic [EC_W-1:0] EC_NONE   = 6'h00;
  localparam logic [EC_W-1:0] EC_SYS64  = 6'h18;
  localparam logic [EC_W-1:0] EC_XFER32 = 6'h03;
  localparam logic [EC_W-1:0] EC_XFER2  = 6'h04;

  typedef enum logic [2:0] {
    TGT_PCNT = 3'd0,
    TGT_VCNT = 3'd1,
    TGT_FREQ = 3'd2,
    TGT_PTMR = 3'd3,
    TGT_VTMR = 3'd4
  } tgt_e;

  typedef enum logic [1:0] {
    STY_SYS64  = 2'd0,
    STY_XFER32 = 2'd1,
    STY_XFER2  = 2'd2,
    STY_RSVD   = 2'd3
  } style_e;

  typedef struct packed {
    logic pcnt;
    logic vcnt;
    logic vtmr;
    logic ptmr;
  } enables_t;
endpackage

// File: rtl/timer_trap_enables.sv
module timer_trap_enables
  import timer_trap_pkg::*;
#(
  parameter int KCTL_W = 32
) (
  input  logic [KCTL_W-1:0] kctl,
  output enables_t          en
);
  // Pick the four enable bits out of the control word; all other bits are dropped here
  always_comb begin
    en.pcnt = kctl[PCNT_EN_BIT];
    en.vcnt = kctl[VCNT_EN_BIT];
    en.vtmr = kctl[VTMR_EN_BIT];
    en.ptmr = kctl[PTMR_EN_BIT];
  end
endmodule

// File: rtl/timer_trap_guard.sv
module timer_trap_guard
  import timer_trap_pkg::*;
(
  input  enables_t   en,
  input  logic [2:0] target,
  output logic       blocked
);
  always_comb begin
    unique case (target)
      TGT_PCNT: blocked = !en.pcnt;
      TGT_VCNT: blocked = !en.vcnt;
      // frequency is reachable when either counter is enabled
      TGT_FREQ: blocked = !(en.pcnt || en.vcnt);
      TGT_PTMR: blocked = !en.ptmr;
      TGT_VTMR: blocked = !en.vtmr;
      default:  blocked = 1'b0;
    endcase
  end
endmodule

// File: rtl/timer_trap_class.sv
module timer_trap_class
  import timer_trap_pkg::*;
(
  input  logic [1:0]      style,
  output logic            style_ok,
  output logic [EC_W-1:0] ec
);
  always_comb begin
    style_ok = 1'b1;
    unique case (style)
      STY_SYS64:  ec = EC_SYS64;
      STY_XFER32: ec = EC_XFER32;
      STY_XFER2:  ec = EC_XFER2;
      default: begin
        ec       = EC_NONE;
        style_ok = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/timer_trap_decoder.sv
module timer_trap_decoder
  import timer_trap_pkg::*;
#(
  parameter int KCTL_W = 32
) (
  input  logic [KCTL_W-1:0] kctl,
  input  logic              host_override,
  input  logic              user_level,
  input  logic [2:0]        target,
  input  logic [1:0]        style,
  output logic              trap,
  output logic [EC_W-1:0]   syndrome
);
  enables_t        en;
  logic            blocked;
  logic            style_ok;
  logic [EC_W-1:0] ec;
  logic            gate_open;

  generate
    if (KCTL_W < MIN_KCTL_W) begin : g_bad_width
      initial $display("timer_trap_decoder: KCTL_W too small");
    end
  endgenerate

  timer_trap_enables #(.KCTL_W(KCTL_W)) u_enables (
    .kctl (kctl),
    .en   (en)
  );

  timer_trap_guard u_guard (
    .en      (en),
    .target  (target),
    .blocked (blocked)
  );

  timer_trap_class u_class (
    .style    (style),
    .style_ok (style_ok),
    .ec       (ec)
  );

  // Only user-level accesses outside host mode are subject to these controls
  assign gate_open = user_level && !host_override;

  always_comb begin
    trap     = gate_open && blocked && style_ok;
    syndrome = trap ? ec : EC_NONE;
  end
endmodule

// File: rtl/timer_trap_checker.sv
module timer_trap_checker
  import timer_trap_pkg::*;
#(
  parameter int KCTL_W = 32
) (
  input logic [KCTL_W-1:0] kctl,
  input logic              host_override,
  input logic              user_level,
  input logic [2:0]        target,
  input logic [1:0]        style,
  input logic              trap,
  input logic [EC_W-1:0]   syndrome
);
  always_comb begin
    if (!$isunknown({kctl, host_override, user_level, target, style, trap, syndrome})) begin
      p_ptmr_open_r1: assert (!(target == 3'd3 && kctl[9] && trap));
      p_vtmr_open_r2: assert (!(target == 3'd4 && kctl[8] && trap));
      p_vcnt_open_r3: assert (!(target == 3'd1 && kctl[1] && trap));
      p_pcnt_open_r4: assert (!(target == 3'd0 && kctl[0] && trap));
      p_freq_open_r5: assert (!(target == 3'd2 && (kctl[0] || kctl[1]) && trap));
      p_sys64_ec_r6:  assert (!(trap && style == 2'd0) || syndrome == 6'h18);
      p_xfer_ec_r7:   assert (!(trap && style == 2'd1) || syndrome == 6'h03);
      p_rsvd_r7:      assert (!(style == 2'd3 && trap));
      p_host_r8:      assert (!(host_override && trap));
      p_priv_r9:      assert (!(!user_level && trap));
      p_zero_ec_r10:  assert (trap || syndrome == 6'h00);
      p_uncov_r11:    assert (!(target > 3'd4 && trap));
    end
  end
endmodule

bind timer_trap_decoder timer_trap_checker #(.KCTL_W(KCTL_W)) u_checker (
  .kctl          (kctl),
  .host_override (host_override),
  .user_level    (user_level),
  .target        (target),
  .style         (style),
  .trap          (trap),
  .syndrome      (syndrome)
);

// File: tb/test_timer_trap_decoder.sv
`timescale 1ns/1ps
module test_timer_trap_decoder;
  localparam int KW = 32;

  logic          clk = 1'b0;
  logic [KW-1:0] kctl = '0;
  logic          host_override = 1'b0;
  logic          user_level = 1'b0;
  logic [2:0]    target = 3'd0;
  logic [1:0]    style = 2'd0;
  logic          trap;
  logic [5:0]    syndrome;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  timer_trap_decoder #(.KCTL_W(KW)) i_timer_trap_decoder (
    .kctl(kctl), .host_override(host_override), .user_level(user_level),
    .target(target), .style(style), .trap(trap), .syndrome(syndrome)
  );

  function automatic logic exp_trap(logic [KW-1:0] k, logic ho, logic ul,
                                    logic [2:0] t, logic [1:0] s);
    logic blk;
    case (t)
      3'd0: blk = !k[0];
      3'd1: blk = !k[1];
      3'd2: blk = !k[0] && !k[1];
      3'd3: blk = !k[9];
      3'd4: blk = !k[8];
      default: blk = 1'b0;
    endcase
    return ul && !ho && blk && (s != 2'd3);
  endfunction

  function automatic logic [5:0] exp_ec(logic tr, logic [1:0] s);
    if (!tr) return 6'h00;
    case (s)
      2'd0: return 6'h18;
      2'd1: return 6'h03;
      2'd2: return 6'h04;
      default: return 6'h00;
    endcase
  endfunction

  task automatic apply(logic [KW-1:0] k, logic ho, logic ul, logic [2:0] t, logic [1:0] s);
    @(negedge clk);
    kctl = k; host_override = ho; user_level = ul; target = t; style = s;
    #1;
  endtask

  task automatic check(string tag);
    logic       et;
    logic [5:0] ee;
    et = exp_trap(kctl, host_override, user_level, target, style);
    ee = exp_ec(et, style);
    n_checks++;
    if (trap !== et || syndrome !== ee) begin
      n_fail++;
      $display("FAIL %s: trap=%0b syndrome=%02h expected trap=%0b syndrome=%02h (kctl=%08h ho=%0b ul=%0b tgt=%0d sty=%0d)",
               tag, trap, syndrome, et, ee, kctl, host_override, user_level, target, style);
    end
  endtask

  function automatic string tag_of(logic [2:0] t);
    case (t)
      3'd0: return "R4";
      3'd1: return "R3";
      3'd2: return "R5";
      3'd3: return "R1";
      3'd4: return "R2";
      default: return "R11";
    endcase
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1357_2468));
    // reset-like idle state: privileged, all zero
    apply('0, 1'b0, 1'b0, 3'd0, 2'd0); check("R9");

    // R1/R2/R3/R4: each enable bit alone, every target
    for (int b = 0; b < 4; b++) begin
      for (int t = 0; t < 5; t++) begin
        logic [KW-1:0] k;
        k = '0;
        case (b)
          0: k[0] = 1'b1;
          1: k[1] = 1'b1;
          2: k[8] = 1'b1;
          default: k[9] = 1'b1;
        endcase
        apply(k, 1'b0, 1'b1, 3'(t), 2'd0); check(tag_of(3'(t)));
        apply(~k, 1'b0, 1'b1, 3'(t), 2'd0); check(tag_of(3'(t)));
      end
    end

    // R5: frequency under all four counter-enable combinations
    for (int c = 0; c < 4; c++) begin
      apply({30'd0, 2'(c)}, 1'b0, 1'b1, 3'd2, 2'd1); check("R5");
    end

    // R6/R7: class codes for each style on a trapping access
    apply('0, 1'b0, 1'b1, 3'd3, 2'd0); check("R6");
    apply('0, 1'b0, 1'b1, 3'd4, 2'd1); check("R7");
    apply('0, 1'b0, 1'b1, 3'd0, 2'd2); check("R7");
    apply('0, 1'b0, 1'b1, 3'd1, 2'd3); check("R7");

    // R8/R9: gating dominates a fully closed control word
    for (int t = 0; t < 5; t++) begin
      apply('0, 1'b1, 1'b1, 3'(t), 2'd0); check("R8");
      apply('0, 1'b0, 1'b0, 3'(t), 2'd1); check("R9");
    end

    // R11: uncovered targets with everything closed
    for (int t = 5; t < 8; t++) begin
      apply('0, 1'b0, 1'b1, 3'(t), 2'd0); check("R11");
    end

    // R12: scrambled unrelated bits with enables held
    for (int i = 0; i < 200; i++) begin
      logic [KW-1:0] k;
      k = $urandom();
      k[0] = 1'b0; k[1] = 1'b0; k[8] = 1'b0; k[9] = 1'b0;
      apply(k, 1'b0, 1'b1, 3'($urandom_range(0, 4)), 2'($urandom_range(0, 2)));
      check("R12");
    end

    // Random mix; R10 zero class whenever no trap is covered by every check
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] t;
      t = 3'($urandom_range(0, 7));
      apply($urandom(), ($urandom_range(0, 7) == 0), ($urandom_range(0, 5) != 0),
            t, 2'($urandom_range(0, 3)));
      check(trap ? tag_of(t) : "R10");
    end

    finish_run();
  end
endmodule